// File: doc/BRIEF.md
# Delta-Sigma ADC Conversion Sequencer

This block is the host side of a serial link to a delta-sigma converter. A single start request runs one full conversion transaction. The block lowers chip select and writes the converter's input multiplexer register with the code captured at start. It then sends a synchronize opcode and a wake-up opcode. It waits for the converter's active-low data-ready line, sends the read-data opcode and clocks in a result of several bytes. Finally it raises chip select and presents the assembled word with a one-cycle strobe.

The block runs entirely on the converter's master clock. The serial clock is that clock divided by an even ratio of at least four. Each opcode is followed by the minimum quiet time that opcode needs before the next serial clock rising edge, counted in master-clock periods. Bytes that belong to the same command follow each other at the normal byte spacing with no added wait. Data is driven on the rising serial clock edge and sampled on the falling edge, most significant bit first.

Top module: `adcseq_top`

## Requirements
- R1: One transaction sends exactly these bytes, MSB first: `{4'b0101, MUX_REG_ADDR[3:0]}` (0x51 with the default address 1), 0x00 (one register), the mux code latched when start was accepted, 0xFC (synchronize), 0x00 (wake-up), 0x01 (read data), then RESULT_BYTES filler bytes of 0x00, for 8*(6+RESULT_BYTES) serial clock pulses in total.
- R2: `sclk` is low whenever `cs_n` is high. Inside a byte every high phase and every low phase lasts exactly CLK_DIV/2 master clocks, so the serial rate is never above one quarter of the master clock.
- R3: `din` changes only together with a rising `sclk` edge and holds its value while `sclk` is high.
- R4: From the last falling edge of one byte to the first rising edge of the next, the gap is exactly CLK_DIV/2+2 master clocks between the three bytes of the register write and between the result bytes.
- R5: The gap after the mux data byte is max(GAP_WRITE, CLK_DIV/2+2) master clocks.
- R6: The gap after the synchronize opcode is max(GAP_SYNC, CLK_DIV/2+2) master clocks.
- R7: When data-ready is already low, the read-data opcode follows the wake-up opcode after the normal CLK_DIV/2+2 gap.
- R8: While `drdy_n` is high, the read-data opcode is not started. It starts after `drdy_n` has gone low.
- R9: The gap after the read-data opcode, up to the first result byte, is max(GAP_READ, CLK_DIV/2+2) master clocks.
- R10: `dout` is sampled on falling `sclk` edges. The result bytes are assembled first byte in the most significant position into `result`.
- R11: `cs_n` falls in the cycle that start is accepted, one master clock before the first rising `sclk` edge. It stays low until it rises in the same cycle that `result_valid` pulses, and `result_valid` lasts exactly one cycle.
- R12: A start request while a transaction is running is ignored. Changes of `mux_code` after acceptance have no effect on the transaction.
- R13: After reset, `cs_n`=1, `sclk`=0, `din`=0, `result_valid`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one conversion transaction (sampled when idle) |
| mux_code | input | 8 | Value written to the multiplexer register |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| dout | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock |
| din | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Chip select, active low |
| result | output | 8*RESULT_BYTES | Assembled conversion result |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The bench builds the block with CLK_DIV=4, the fastest legal serial rate, and the default gaps of 4, 24 and 50 master clocks. At this ratio the normal byte spacing of 4 equals the write minimum. This puts the write gap exactly on its limit, while the synchronize and read-data gaps run through the gap timer with reloads of 19 and 45. Each transaction measures every phase width and every inter-byte gap, and compares each gap with its own expected value. Directed runs also hold data-ready high past the wake-up opcode, poke start mid-transaction, and use all-ones, all-zeros and alternating result patterns.

// File: rtl/adcseq_pkg.sv
// Package: shared types, opcodes and step numbering for the conversion
// sequencer. Assumes the fixed transaction order register-write header,
// count, data, synchronize, wake-up, read-data, then result bytes.
package adcseq_pkg;

    // Opcode nibbles and bytes the converter decodes
    localparam logic [3:0] OP_WRITE_NIB = 4'h5;
    localparam logic [7:0] OP_SYNC      = 8'hFC;
    localparam logic [7:0] OP_WAKE      = 8'h00;
    localparam logic [7:0] OP_RDATA     = 8'h01;
    localparam logic [7:0] FILL_BYTE    = 8'h00;

    // Step numbers of one transaction, in transmission order
    localparam int STEP_WR_HDR  = 0;
    localparam int STEP_WR_CNT  = 1;
    localparam int STEP_WR_DATA = 2;
    localparam int STEP_SYNC    = 3;
    localparam int STEP_WAKE    = 4;
    localparam int STEP_RDATA   = 5;
    localparam int STEP_READ0   = 6;

    // Quiet-time class that follows a byte
    typedef enum logic [1:0] {
        GK_NONE,
        GK_WRITE,
        GK_SYNC,
        GK_READ
    } gap_kind_e;

    // Sequencer control states
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_GAP,
        SQ_DRDY
    } seq_state_e;

    // Which quiet time must follow the byte sent at step s
    function automatic gap_kind_e step_gap(input int s);
        case (s)
            STEP_WR_DATA: return GK_WRITE;
            STEP_SYNC:    return GK_SYNC;
            STEP_RDATA:   return GK_READ;
            default:      return GK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/adcseq_drdy_sync.sv
// Module: brings the asynchronous active-low data-ready line into the
// master clock domain through STAGES flops and presents it active high.
// Assumes STAGES >= 0; zero stages means a plain inversion.
module adcseq_drdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n,
    output logic ready
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign ready = ~drdy_n;
        end else begin : g_chain
            logic [STAGES-1:0] q;

            // First stage samples the raw pin, reset to "not ready"
            always_ff @(posedge clk) begin
                if (!rst_n) q[0] <= 1'b1;
                else        q[0] <= drdy_n;
            end

            for (genvar i = 1; i < STAGES; i++) begin : g_stage
                // Each further stage retimes the previous one
                always_ff @(posedge clk) begin
                    if (!rst_n) q[i] <= 1'b1;
                    else        q[i] <= q[i-1];
                end
            end

            assign ready = ~q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/adcseq_shifter.sv
// Module: byte engine of the serial link. On go (while idle) it sends one
// byte MSB first and receives one byte at the same time. The high and low
// phases each last CLK_DIV/2 master clocks; din moves with the rising edge
// and dout is captured with the falling edge. done pulses CLK_DIV/2 clocks
// after the last falling edge. Assumes CLK_DIV is even and at least 4.
module adcseq_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       dout,
    output logic       sclk,
    output logic       din,
    output logic [7:0] rx_byte,
    output logic       done
);

    localparam int HALF = CLK_DIV / 2;
    localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

    logic            active;
    logic [PH_W-1:0] ph_cnt;
    logic [2:0]      bit_idx;
    logic [7:0]      tx_hold;
    logic [7:0]      rx_shift;
    logic            sclk_q;
    logic            din_q;

    // Phase timing, bit stepping and data shifting of one byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            ph_cnt   <= '0;
            bit_idx  <= '0;
            tx_hold  <= '0;
            rx_shift <= '0;
            sclk_q   <= 1'b0;
            din_q    <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    sclk_q  <= 1'b1;
                    din_q   <= tx_byte[7];
                    tx_hold <= tx_byte;
                    bit_idx <= 3'd7;
                    ph_cnt  <= '0;
                end
            end else if (ph_cnt != PH_LAST) begin
                ph_cnt <= ph_cnt + 1'b1;
            end else begin
                ph_cnt <= '0;
                if (sclk_q) begin
                    sclk_q   <= 1'b0;
                    rx_shift <= {rx_shift[6:0], dout};
                end else if (bit_idx == 3'd0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    sclk_q  <= 1'b1;
                    bit_idx <= bit_idx - 3'd1;
                    din_q   <= tx_hold[bit_idx - 3'd1];
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign din     = din_q;
    assign rx_byte = rx_shift;

endmodule

// File: rtl/adcseq_gap_timer.sv
// Module: down-counter for the extra quiet time after a command. load
// sets the count; expired is high whenever the count is zero. Assumes the
// controller loads it in the same cycle that it enters its wait state.
module adcseq_gap_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/adcseq_ctrl.sv
// Module: transaction controller. Walks the fixed step list, picks the
// byte for each step, decides after every byte whether to go on at once,
// wait on the gap timer or wait for data-ready, assembles the result and
// owns chip select. Assumes the shifter's done pulse arrives CLK_DIV/2
// clocks after its last falling edge, so the gap from that edge to the
// next rising edge is CLK_DIV/2+2 without a wait and N with a wait of
// N-CLK_DIV/2-3 timer counts.
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int GAP_WRITE    = 4,
    parameter int GAP_SYNC     = 24,
    parameter int GAP_READ     = 50,
    parameter int RESULT_BYTES = 3,
    parameter int MUX_REG_ADDR = 1,
    parameter int TMR_W        = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [7:0]                mux_code,
    input  logic                      ready,
    input  logic                      sh_done,
    input  logic [7:0]                rx_byte,
    input  logic                      tmr_expired,
    output logic                      go,
    output logic [7:0]                tx_byte,
    output logic                      tmr_load,
    output logic [TMR_W-1:0]          tmr_val,
    output logic                      cs_n,
    output logic [8*RESULT_BYTES-1:0] result,
    output logic                      result_valid
);

    localparam int HALF      = CLK_DIV / 2;
    localparam int SPACING   = HALF + 2;
    localparam int RES_W     = 8 * RESULT_BYTES;
    localparam int LAST_STEP = STEP_READ0 + RESULT_BYTES - 1;
    localparam int STEP_W    = $clog2(LAST_STEP + 1);

    localparam bit NEED_W = GAP_WRITE > SPACING;
    localparam bit NEED_S = GAP_SYNC  > SPACING;
    localparam bit NEED_R = GAP_READ  > SPACING;
    localparam logic [TMR_W-1:0] EXTRA_W = NEED_W ? TMR_W'(GAP_WRITE - SPACING - 1) : '0;
    localparam logic [TMR_W-1:0] EXTRA_S = NEED_S ? TMR_W'(GAP_SYNC  - SPACING - 1) : '0;
    localparam logic [TMR_W-1:0] EXTRA_R = NEED_R ? TMR_W'(GAP_READ  - SPACING - 1) : '0;

    seq_state_e        state;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] nxt_step;
    logic [7:0]        mux_q;
    logic [RES_W-1:0]  acc;
    logic [RES_W+7:0]  acc_ext;
    logic              is_last;
    logic              is_read;
    logic              need_wait;
    logic [TMR_W-1:0]  wait_val;

    // Byte that goes out at a given step
    function automatic logic [7:0] byte_for(input logic [STEP_W-1:0] s,
                                            input logic [7:0] m);
        case (int'(s))
            STEP_WR_HDR:  return {OP_WRITE_NIB, 4'(MUX_REG_ADDR)};
            STEP_WR_CNT:  return 8'h00;
            STEP_WR_DATA: return m;
            STEP_SYNC:    return OP_SYNC;
            STEP_WAKE:    return OP_WAKE;
            STEP_RDATA:   return OP_RDATA;
            default:      return FILL_BYTE;
        endcase
    endfunction

    // Decode of the current step and the quiet time it demands
    always_comb begin
        nxt_step = step + 1'b1;
        is_last  = int'(step) == LAST_STEP;
        is_read  = int'(step) >= STEP_READ0;
        acc_ext  = {acc, rx_byte};
        case (step_gap(int'(step)))
            GK_WRITE: begin need_wait = NEED_W; wait_val = EXTRA_W; end
            GK_SYNC:  begin need_wait = NEED_S; wait_val = EXTRA_S; end
            GK_READ:  begin need_wait = NEED_R; wait_val = EXTRA_R; end
            default:  begin need_wait = 1'b0;   wait_val = '0;      end
        endcase
        tmr_load = (state == SQ_SHIFT) && sh_done && !is_last && need_wait;
        tmr_val  = wait_val;
    end

    // Step sequencing, chip select, result assembly and output strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SQ_IDLE;
            step         <= '0;
            mux_q        <= '0;
            acc          <= '0;
            go           <= 1'b0;
            tx_byte      <= '0;
            cs_n         <= 1'b1;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            go           <= 1'b0;
            result_valid <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        cs_n    <= 1'b0;
                        mux_q   <= mux_code;
                        step    <= '0;
                        acc     <= '0;
                        go      <= 1'b1;
                        tx_byte <= byte_for('0, mux_code);
                        state   <= SQ_SHIFT;
                    end
                end
                SQ_SHIFT: begin
                    if (sh_done) begin
                        if (is_read) acc <= acc_ext[RES_W-1:0];
                        if (is_last) begin
                            result       <= acc_ext[RES_W-1:0];
                            result_valid <= 1'b1;
                            cs_n         <= 1'b1;
                            state        <= SQ_IDLE;
                        end else begin
                            step <= nxt_step;
                            if (need_wait) begin
                                state <= SQ_GAP;
                            end else if (int'(nxt_step) == STEP_RDATA && !ready) begin
                                state <= SQ_DRDY;
                            end else begin
                                go      <= 1'b1;
                                tx_byte <= byte_for(nxt_step, mux_q);
                            end
                        end
                    end
                end
                SQ_GAP: begin
                    if (tmr_expired) begin
                        if (int'(step) == STEP_RDATA && !ready) begin
                            state <= SQ_DRDY;
                        end else begin
                            go      <= 1'b1;
                            tx_byte <= byte_for(step, mux_q);
                            state   <= SQ_SHIFT;
                        end
                    end
                end
                SQ_DRDY: begin
                    if (ready) begin
                        go      <= 1'b1;
                        tx_byte <= byte_for(step, mux_q);
                        state   <= SQ_SHIFT;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adcseq_top.sv
// Module: top of the conversion sequencer. Ties the data-ready
// synchronizer, the byte engine, the gap timer and the controller
// together. Assumes clk is the converter master clock and that CLK_DIV is
// even and at least 4.
module adcseq_top #(
    parameter int CLK_DIV      = 4,
    parameter int GAP_WRITE    = 4,
    parameter int GAP_SYNC     = 24,
    parameter int GAP_READ     = 50,
    parameter int RESULT_BYTES = 3,
    parameter int MUX_REG_ADDR = 1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [7:0]                mux_code,
    input  logic                      drdy_n,
    input  logic                      dout,
    output logic                      sclk,
    output logic                      din,
    output logic                      cs_n,
    output logic [8*RESULT_BYTES-1:0] result,
    output logic                      result_valid
);

    localparam int MAX_GAP0 = (GAP_WRITE > GAP_SYNC) ? GAP_WRITE : GAP_SYNC;
    localparam int MAX_GAP  = (MAX_GAP0 > GAP_READ) ? MAX_GAP0 : GAP_READ;
    localparam int TMR_W    = $clog2(MAX_GAP + 1);

    logic             ready;
    logic             go;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic             sh_done;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;

    adcseq_drdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .drdy_n (drdy_n),
        .ready  (ready)
    );

    adcseq_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tx_byte (tx_byte),
        .dout    (dout),
        .sclk    (sclk),
        .din     (din),
        .rx_byte (rx_byte),
        .done    (sh_done)
    );

    adcseq_gap_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    adcseq_ctrl #(
        .CLK_DIV      (CLK_DIV),
        .GAP_WRITE    (GAP_WRITE),
        .GAP_SYNC     (GAP_SYNC),
        .GAP_READ     (GAP_READ),
        .RESULT_BYTES (RESULT_BYTES),
        .MUX_REG_ADDR (MUX_REG_ADDR),
        .TMR_W        (TMR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mux_code     (mux_code),
        .ready        (ready),
        .sh_done      (sh_done),
        .rx_byte      (rx_byte),
        .tmr_expired  (tmr_expired),
        .go           (go),
        .tx_byte      (tx_byte),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .cs_n         (cs_n),
        .result       (result),
        .result_valid (result_valid)
    );

endmodule

// File: rtl/adcseq_chk.sv
// Module: property checker for the sequencer's pins, bound to every
// instance of the top module. Assumes reset is held for at least one edge.
module adcseq_chk #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic din,
    input logic cs_n,
    input logic result_valid
);

    localparam int HALF = CLK_DIV / 2;

    logic [15:0] hi_cnt;

    // Length of the current high phase of the serial clock
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_cnt <= '0;
        else if (sclk) hi_cnt <= hi_cnt + 16'd1;
        else           hi_cnt <= '0;
    end

    // R2
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2
    sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_cnt == 16'(HALF));

    // R3
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(din));

    // R11
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R11
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> result_valid);

    // R11
    valid_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> cs_n);

endmodule

bind adcseq_top adcseq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .din          (din),
    .cs_n         (cs_n),
    .result_valid (result_valid)
);

// File: tb/adcseq_top_test.sv
module adcseq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;
    localparam int GAP_WRITE  = 4;
    localparam int GAP_SYNC   = 24;
    localparam int GAP_READ   = 50;
    localparam int HALF       = CLK_DIV / 2;
    localparam int SPACING    = HALF + 2;
    localparam int NBYTES     = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mux_code = 8'h00;
    logic        drdy_n = 1'b0;
    logic        dout_r = 1'b0;
    logic        sclk, din, cs_n, result_valid;
    logic [23:0] result;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcseq_top #(
        .CLK_DIV   (CLK_DIV),
        .GAP_WRITE (GAP_WRITE),
        .GAP_SYNC  (GAP_SYNC),
        .GAP_READ  (GAP_READ)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mux_code     (mux_code),
        .drdy_n       (drdy_n),
        .dout         (dout_r),
        .sclk         (sclk),
        .din          (din),
        .cs_n         (cs_n),
        .result       (result),
        .result_valid (result_valid)
    );

    // Converter-side model and link monitor
    logic [23:0] adc_word = '0;
    int          cyc = 0, nbits = 0, last_fall = 0, last_rise = 0, cs_fall = 0;
    int          first_rise = -1, phase_err = 0, din_err = 0;
    int          valid_cnt = 0, cs_fall_cnt = 0;
    int          gaps [0:15];
    logic [7:0]  bytes [0:15];
    logic [7:0]  cur = '0;
    logic        prev_sclk = 1'b0, prev_cs = 1'b1, din_at_rise = 1'b0;
    logic        cs_at_valid = 1'b0;
    logic [23:0] res_cap = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_sclk = 1'b0;
            prev_cs   = 1'b1;
        end else begin
            if (prev_cs && !cs_n) begin
                nbits = 0; cs_fall = cyc; first_rise = -1;
                phase_err = 0; din_err = 0; cs_fall_cnt++;
                for (int i = 0; i < 16; i++) begin gaps[i] = -1; bytes[i] = 8'hxx; end
            end
            if (!prev_sclk && sclk) begin
                if (nbits == 0) first_rise = cyc - cs_fall;
                else if (nbits % 8 == 0) begin
                    if (nbits / 8 < 16) gaps[nbits/8] = cyc - last_fall;
                end else if (cyc - last_fall != HALF) phase_err++;
                last_rise   = cyc;
                din_at_rise = din;
                cur         = {cur[6:0], din};
                if (nbits / 8 >= 6 && nbits / 8 < NBYTES)
                    dout_r = adc_word[23 - 8*(nbits/8 - 6) - (nbits % 8)];
                else
                    dout_r = 1'b0;
            end else if (prev_sclk && sclk && din != din_at_rise) begin
                din_err++;
            end
            if (prev_sclk && !sclk) begin
                if (cyc - last_rise != HALF) phase_err++;
                if (din != din_at_rise) din_err++;
                last_fall = cyc;
                nbits++;
                if (nbits % 8 == 0 && nbits / 8 <= 16) bytes[nbits/8 - 1] = cur;
            end
            if (result_valid) begin
                valid_cnt++;
                res_cap     = result;
                cs_at_valid = cs_n;
            end
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end

    // Expected byte at position k
    function automatic logic [7:0] exp_byte(input int k, input logic [7:0] m);
        case (k)
            0: return 8'h51;
            1: return 8'h00;
            2: return m;
            3: return 8'hFC;
            4: return 8'h00;
            5: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected gap before byte k
    function automatic int exp_gap(input int k);
        case (k)
            3: return maxi(GAP_WRITE, SPACING);
            4: return maxi(GAP_SYNC, SPACING);
            6: return maxi(GAP_READ, SPACING);
            default: return SPACING;
        endcase
    endfunction

    function automatic string gap_tag(input int k);
        case (k)
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic run_seq(input logic [7:0] mux, input logic [23:0] word,
                           input bit gate_drdy, input bit poke);
        int base_valid, base_fall, guard;
        adc_word   = word;
        drdy_n     = gate_drdy;
        base_valid = valid_cnt;
        base_fall  = cs_fall_cnt;
        mux_code   = mux;
        start      = 1'b1;
        tick();
        start      = 1'b0;
        mux_code   = ~mux;                       // R12: late change ignored
        if (poke) begin
            repeat (60) tick();
            start = 1'b1;                        // R12: mid-run request
            mux_code = mux ^ 8'h5A;
            tick();
            start = 1'b0;
        end
        if (gate_drdy) begin
            guard = 0;
            while (nbits < 40 && guard < 5000) begin tick(); guard++; end
            repeat (200) tick();
            // R8: read-data opcode held back while data-ready is high
            check(nbits == 40, "R8", nbits, 40);
            drdy_n = 1'b0;
        end
        guard = 0;
        while (valid_cnt == base_valid && guard < 5000) begin tick(); guard++; end
        repeat (40) tick();
        check(nbits == 8 * NBYTES, "R1", nbits, 8 * NBYTES);
        for (int k = 0; k < 6; k++)
            check(bytes[k] === exp_byte(k, mux), "R1", bytes[k], exp_byte(k, mux));
        for (int k = 1; k < NBYTES; k++) begin
            if (gate_drdy && k == 5)
                check(gaps[k] > 200, "R8", gaps[k], 200);
            else
                check(gaps[k] == exp_gap(k), gap_tag(k), gaps[k], exp_gap(k));
        end
        check(phase_err == 0, "R2", phase_err, 0);
        check(din_err == 0, "R3", din_err, 0);
        check(res_cap == word, "R10", res_cap, word);
        check(valid_cnt - base_valid == 1, "R11", valid_cnt - base_valid, 1);
        check(cs_at_valid == 1'b1, "R11", cs_at_valid, 1);
        check(first_rise == 1, "R11", first_rise, 1);
        check(cs_fall_cnt - base_fall == 1, "R12", cs_fall_cnt - base_fall, 1);
        check(cs_n == 1'b1 && sclk == 1'b0, "R12", {cs_n, sclk}, 2'b10);
        drdy_n = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) tick();
        // R13: reset values
        check(cs_n == 1'b1, "R13", cs_n, 1);
        check(sclk == 1'b0 && din == 1'b0, "R13", {sclk, din}, 0);
        check(result_valid == 1'b0 && result == '0, "R13", result, 0);
        rst_n = 1'b1;
        repeat (3) tick();
        check(cs_n == 1'b1 && sclk == 1'b0 && result_valid == 1'b0, "R13",
              {cs_n, sclk, result_valid}, 3'b100);

        // Directed corners
        run_seq(8'h01, 24'hFFFFFF, 1'b0, 1'b0);
        run_seq(8'hFF, 24'h000000, 1'b0, 1'b0);
        run_seq(8'h23, 24'hA5A5A5, 1'b1, 1'b0);
        run_seq(8'h45, 24'h800001, 1'b0, 1'b1);

        // Constrained random transactions
        for (int i = 0; i < 8; i++) begin
            logic [7:0]  m;
            logic [23:0] w;
            m = 8'($urandom);
            w = 24'($urandom);
            run_seq(m, w, ($urandom % 4) == 0, ($urandom % 4) == 0);
        end

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule